// File: doc/BRIEF.md
# Line-Doubled Virtual Scanline Counter

This block follows the beam through a 640x480 VGA frame and reports a virtual scanline number at half the physical vertical resolution. It serves a legacy-style video processor that draws each of its lines twice. The physical line counter runs through 525 lines per frame, and each line is 800 pixel enables long. The reported line is the physical line divided by two. It stays at each value for exactly two physical lines, and it saturates at 255 through the rest of vertical blanking instead of wrapping.

A vertical interrupt flag rises when the virtual line enters the first blanked line. That is line 192 in 24-row mode and line 240 in 30-row mode. The flag stays up until a status read or the start of the next frame. A per-line horizontal interrupt pulse marks the start of every virtual line, but only while its enable bit is set. A sprite-preprocess level is high during the virtual line before each displayed line, so that sprite table changes made during a line apply to the next one.

Top module: `vscan_line_doubler`

## Requirements
- R1: The physical line advances once every H_TOTAL (default 800) clocks with `pix_en_i` high. Clocks with `pix_en_i` low change nothing.
- R2: `line_o` equals the physical line divided by two. It changes only at the start of an even physical line, so each value lasts two physical lines.
- R3: From physical line 510 through 524, `line_o` holds at 255. After physical line 524 the frame wraps to physical line 0 and `line_o` returns to 0.
- R4: With `row30_i`=0 (24-row mode), `vint_flag_o` rises at the start of virtual line 192 (physical line 384). It is 0 during virtual line 191.
- R5: With `row30_i`=1 (30-row mode), `vint_flag_o` stays 0 through virtual line 239 and rises at the start of virtual line 240 (physical line 480).
- R6: A one-clock `status_rd_i` pulse clears `vint_flag_o` on the next edge. The start of a new frame also clears it. Once cleared, it stays 0 until the next rise point.
- R7: `vint_irq_o` is high only while both `vint_flag_o` and `vint_en_i` are 1.
- R8: With `hint_en_i`=1, `hint_o` is a one-clock pulse that starts with each even physical line. There is no pulse at odd physical lines, and none at all while `hint_en_i`=0.
- R9: `sprite_pre_o` is 1 while the unsaturated virtual line v = physical/2 is below (visible lines - 1), or while the physical line is 524. Otherwise it is 0.
- R10: After reset, the block is at physical line 0 with `line_o`=0, `vint_flag_o`=0, `hint_o`=0 and `sprite_pre_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pix_en_i | input | 1 | Pixel-clock enable |
| row30_i | input | 1 | 0: 24-row mode, 1: 30-row mode |
| hint_en_i | input | 1 | Horizontal interrupt enable |
| vint_en_i | input | 1 | Vertical interrupt output enable |
| status_rd_i | input | 1 | Status read strobe, clears vertical flag |
| line_o | output | 8 | Current virtual scanline |
| vint_flag_o | output | 1 | Vertical interrupt flag |
| vint_irq_o | output | 1 | Gated vertical interrupt |
| hint_o | output | 1 | Per-line interrupt pulse |
| sprite_pre_o | output | 1 | Sprite preprocess window |

## Verification
The bench walks several frames in both row modes and samples at the line boundaries around 191/192, 239/240, 255/256 and the frame wrap. A design that wraps the counter instead of saturating would show 0 instead of 255 at physical line 512. A design that uses the wrong mode limit would raise the vertical flag 48 virtual lines early or late. The bench also probes the sprite window at the line before the last visible line and at the final physical line, where an off-by-one shows up directly. It checks that the per-line pulse appears only at even physical lines and only when enabled. Finally, it checks that a status read clears the flag, that the flag is not set again later in the same frame, and that stalled pixel enables freeze the count.

// File: rtl/vscan_pkg.sv
package vscan_pkg;
  typedef struct packed {
    logic new_vline;
    logic frame_wrap;
    logic vis_hit;
  } line_evt_t;
endpackage

// File: rtl/vscan_hcount.sv
module vscan_hcount #(
  parameter int H_TOTAL = 800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pix_en_i,
  output logic line_end_o
);
  localparam int CW = (H_TOTAL > 1) ? $clog2(H_TOTAL) : 1;
  localparam logic [CW-1:0] H_LAST = CW'(H_TOTAL - 1);

  logic [CW-1:0] hcnt_q;

  assign line_end_o = pix_en_i && (hcnt_q == H_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hcnt_q <= '0;
    else if (line_end_o) hcnt_q <= '0;
    else if (pix_en_i) hcnt_q <= hcnt_q + 1'b1;
  end
endmodule

// File: rtl/vscan_vcount.sv
module vscan_vcount
  import vscan_pkg::*;
#(
  parameter int V_TOTAL = 525,
  parameter int VIS24   = 192,
  parameter int VIS30   = 240,
  parameter int LINE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_end_i,
  input  logic              row30_i,
  output line_evt_t         evt_o,
  output logic [LINE_W-1:0] vline_o,
  output logic              sprite_pre_o
);
  localparam int PW = $clog2(V_TOTAL);
  localparam int RW = PW - 1;
  localparam logic [PW-1:0] P_LAST = PW'(V_TOTAL - 1);
  localparam logic [RW-1:0] R_VIS24 = RW'(VIS24);
  localparam logic [RW-1:0] R_VIS30 = RW'(VIS30);

  logic [PW-1:0]     phys_q, phys_nxt;
  logic [RW-1:0]     raw_cur, raw_nxt, r_vis;
  logic [LINE_W-1:0] vline_q, vline_nxt;
  logic              last_line;

  assign last_line = (phys_q == P_LAST);
  assign phys_nxt  = last_line ? '0 : phys_q + 1'b1;
  assign raw_nxt   = phys_nxt[PW-1:1];
  assign raw_cur   = phys_q[PW-1:1];
  assign r_vis     = row30_i ? R_VIS30 : R_VIS24;

  generate
    if (RW > LINE_W) begin : g_sat
      localparam logic [RW-1:0] R_MAX = RW'((1 << LINE_W) - 1);
      assign vline_nxt = (raw_nxt > R_MAX) ? {LINE_W{1'b1}} : raw_nxt[LINE_W-1:0];
    end else begin : g_nosat
      assign vline_nxt = LINE_W'(raw_nxt);
    end
  endgenerate

  assign evt_o.new_vline  = line_end_i && !phys_nxt[0];
  assign evt_o.frame_wrap = line_end_i && last_line;
  assign evt_o.vis_hit    = evt_o.new_vline && (raw_nxt == r_vis);

  // next virtual line is displayed: current raw below vis-1, or last line of frame
  assign sprite_pre_o = (raw_cur < (r_vis - 1'b1)) || last_line;
  assign vline_o      = vline_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phys_q  <= '0;
      vline_q <= '0;
    end else if (line_end_i) begin
      phys_q <= phys_nxt;
      if (!phys_nxt[0]) vline_q <= vline_nxt;
    end
  end
endmodule

// File: rtl/vscan_irq.sv
module vscan_irq
  import vscan_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_evt_t evt_i,
  input  logic      hint_en_i,
  input  logic      vint_en_i,
  input  logic      status_rd_i,
  output logic      vint_flag_o,
  output logic      vint_irq_o,
  output logic      hint_o
);
  logic vint_q, hint_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vint_q <= 1'b0;
      hint_q <= 1'b0;
    end else begin
      hint_q <= evt_i.new_vline && hint_en_i;
      if (evt_i.vis_hit) vint_q <= 1'b1;
      else if (evt_i.frame_wrap || status_rd_i) vint_q <= 1'b0;
    end
  end

  assign vint_flag_o = vint_q;
  assign vint_irq_o  = vint_q && vint_en_i;
  assign hint_o      = hint_q;
endmodule

// File: rtl/vscan_line_doubler.sv
module vscan_line_doubler
  import vscan_pkg::*;
#(
  parameter int H_TOTAL = 800,
  parameter int V_TOTAL = 525,
  parameter int VIS24   = 192,
  parameter int VIS30   = 240,
  parameter int LINE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_en_i,
  input  logic              row30_i,
  input  logic              hint_en_i,
  input  logic              vint_en_i,
  input  logic              status_rd_i,
  output logic [LINE_W-1:0] line_o,
  output logic              vint_flag_o,
  output logic              vint_irq_o,
  output logic              hint_o,
  output logic              sprite_pre_o
);
  logic      line_end;
  line_evt_t evt;

  vscan_hcount #(.H_TOTAL(H_TOTAL)) u_hcount (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pix_en_i  (pix_en_i),
    .line_end_o(line_end)
  );

  vscan_vcount #(
    .V_TOTAL(V_TOTAL), .VIS24(VIS24), .VIS30(VIS30), .LINE_W(LINE_W)
  ) u_vcount (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_end_i  (line_end),
    .row30_i     (row30_i),
    .evt_o       (evt),
    .vline_o     (line_o),
    .sprite_pre_o(sprite_pre_o)
  );

  vscan_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .hint_en_i  (hint_en_i),
    .vint_en_i  (vint_en_i),
    .status_rd_i(status_rd_i),
    .vint_flag_o(vint_flag_o),
    .vint_irq_o (vint_irq_o),
    .hint_o     (hint_o)
  );
endmodule

// File: rtl/vscan_checker.sv
module vscan_checker #(
  parameter int VIS24  = 192,
  parameter int VIS30  = 240,
  parameter int LINE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              row30_i,
  input logic              hint_en_i,
  input logic              status_rd_i,
  input logic [LINE_W-1:0] line_o,
  input logic              vint_flag_o,
  input logic              hint_o
);
  localparam logic [LINE_W-1:0] L_MAX = {LINE_W{1'b1}};

  assert_line_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_o) |-> (line_o == $past(line_o) + 1'b1) || (line_o == '0));

  assert_sat_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(line_o) == L_MAX) |-> (line_o == L_MAX) || (line_o == '0));

  assert_vint_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(vint_flag_o) && !$past(row30_i)) |-> (line_o == LINE_W'(VIS24)));

  assert_vint_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(vint_flag_o) && $past(row30_i)) |-> (line_o == LINE_W'(VIS30)));

  assert_rd_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rd_i |=> (!vint_flag_o || !$stable(line_o)));

  assert_hint_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hint_o |=> !hint_o);

  assert_hint_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hint_o |-> ($past(hint_en_i) && !$stable(line_o)) || ($past(hint_en_i) && line_o == L_MAX));
endmodule

bind vscan_line_doubler vscan_checker #(
  .VIS24(VIS24), .VIS30(VIS30), .LINE_W(LINE_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .row30_i    (row30_i),
  .hint_en_i  (hint_en_i),
  .status_rd_i(status_rd_i),
  .line_o     (line_o),
  .vint_flag_o(vint_flag_o),
  .hint_o     (hint_o)
);

// File: tb/vscan_line_doubler_bench.sv
`timescale 1ns/1ps
module vscan_line_doubler_bench;
  localparam int H = 8;
  localparam int V = 525;
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pix_en_i = 0, row30_i = 0, hint_en_i = 0, vint_en_i = 0, status_rd_i = 0;
  logic [7:0] line_o;
  logic vint_flag_o, vint_irq_o, hint_o, sprite_pre_o;

  int checks = 0, errors = 0, cur = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vscan_line_doubler #(.H_TOTAL(H)) u_vscan_line_doubler (
    .clk_i(clk), .rst_ni(rst_ni), .pix_en_i(pix_en_i), .row30_i(row30_i),
    .hint_en_i(hint_en_i), .vint_en_i(vint_en_i), .status_rd_i(status_rd_i),
    .line_o(line_o), .vint_flag_o(vint_flag_o), .vint_irq_o(vint_irq_o),
    .hint_o(hint_o), .sprite_pre_o(sprite_pre_o)
  );

  // {row30, phys, line, vint, sprite_pre}
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 10'd0,   8'd0,   1'b0, 1'b1},
    {1'b0, 10'd1,   8'd0,   1'b0, 1'b1},
    {1'b0, 10'd2,   8'd1,   1'b0, 1'b1},
    {1'b0, 10'd189, 8'd94,  1'b0, 1'b1},
    {1'b0, 10'd380, 8'd190, 1'b0, 1'b1},
    {1'b0, 10'd382, 8'd191, 1'b0, 1'b0},
    {1'b0, 10'd384, 8'd192, 1'b1, 1'b0},
    {1'b0, 10'd510, 8'd255, 1'b1, 1'b0},
    {1'b0, 10'd512, 8'd255, 1'b1, 1'b0},
    {1'b0, 10'd524, 8'd255, 1'b1, 1'b1},
    {1'b1, 10'd0,   8'd0,   1'b0, 1'b1},
    {1'b1, 10'd384, 8'd192, 1'b0, 1'b1},
    {1'b1, 10'd476, 8'd238, 1'b0, 1'b1},
    {1'b1, 10'd478, 8'd239, 1'b0, 1'b0},
    {1'b1, 10'd480, 8'd240, 1'b1, 1'b0},
    {1'b1, 10'd524, 8'd255, 1'b1, 1'b1},
    {1'b0, 10'd0,   8'd0,   1'b0, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pix(input int n);
    pix_en_i = 1'b1;
    repeat (n) @(negedge clk);
    pix_en_i = 1'b0;
  endtask

  task automatic goto_line(input int target);
    int n;
    n = (target - cur + V) % V;
    if (n > 0) pix(n * H);
    cur = target;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 line", line_o, 0);
    chk("R10 vint", vint_flag_o, 0);
    chk("R10 hint", hint_o, 0);
    chk("R10 sprite_pre", sprite_pre_o, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10 line after release", line_o, 0);

    for (int i = 0; i < NV; i++) begin
      row30_i = VEC[i][20];
      goto_line(int'(VEC[i][19:10]));
      chk($sformatf("R2/R3 line at phys %0d", cur), line_o, int'(VEC[i][9:2]));
      chk($sformatf("R4/R5/R6 vint at phys %0d", cur), vint_flag_o, int'(VEC[i][1]));
      chk($sformatf("R9 sprite_pre at phys %0d", cur), sprite_pre_o, int'(VEC[i][0]));
      chk("R8 hint off", hint_o, 0);
    end

    // R1 pixel counting and stall
    goto_line(1);
    repeat (40) @(negedge clk);
    chk("R1 stalled", line_o, 0);
    pix(H - 1);
    chk("R1 before line end", line_o, 0);
    pix(1);
    chk("R1 at line end", line_o, 1);
    cur = 2;

    // R8 per-line pulse
    hint_en_i = 1'b1;
    pix(H);
    chk("R8 no pulse at odd line", hint_o, 0);
    pix(H);
    chk("R8 pulse at even line", hint_o, 1);
    @(negedge clk);
    chk("R8 pulse one clock", hint_o, 0);
    hint_en_i = 1'b0;
    cur = 4;

    // R6/R7 status read and gating
    goto_line(384);
    chk("R4 vint set", vint_flag_o, 1);
    chk("R7 irq gated off", vint_irq_o, 0);
    vint_en_i = 1'b1;
    @(negedge clk);
    chk("R7 irq on", vint_irq_o, 1);
    status_rd_i = 1'b1;
    @(negedge clk);
    status_rd_i = 1'b0;
    chk("R6 cleared by read", vint_flag_o, 0);
    chk("R7 irq off after read", vint_irq_o, 0);
    goto_line(386);
    chk("R6 stays clear", vint_flag_o, 0);
    vint_en_i = 1'b0;

    // R6 frame start clears
    goto_line(0);
    goto_line(390);
    chk("R4 vint set again", vint_flag_o, 1);
    goto_line(0);
    chk("R6 cleared at frame start", vint_flag_o, 0);
    chk("R3 line back to 0", line_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule